// File: doc/BRIEF.md
# Presettable cascadable binary counter

This block is a synchronous binary up-counter, four bits wide by default. It advances by one on a rising clock edge when both of its count enables are high. An active-low parallel-load input replaces the count with a preset word on the next rising edge. An active-low clear forces the count to zero at once, with no clock edge needed.

The block has two enables with different jobs. The parallel enable is meant to be broadcast to every stage of a chain. The trickle enable also gates the terminal-count flag, which is high only while the count is all ones and the trickle enable is high. A wider counter is built from several stages in one of two ways:

- Feed each stage's terminal count into the trickle enable of the next stage, with the parallel enable shared by all stages.
- Feed each terminal count into both enables of the next stage.

Top module: `cascade_cnt`

## Requirements
- R1: While rst_ni is low, count_o is zero. The clear acts asynchronously: count_o drops to zero without waiting for a clock edge.
- R2: When load_ni is low and rst_ni is high, the rising edge loads preset_i into count_o. This happens whatever cnt_en_i and trk_en_i are.
- R3: When load_ni, cnt_en_i and trk_en_i are all high, each rising edge adds one to count_o.
- R4: When load_ni is high and either enable is low, count_o keeps its value across the edge.
- R5: An enabled edge with count_o at all ones (4'b1111 by default) wraps count_o to zero.
- R6: tc_o is high exactly when count_o is all ones and trk_en_i is high. It is combinational and does not depend on cnt_en_i.
- R7: Two stages form an 8-bit counter when wired as follows. The low stage takes the shared parallel enable. The high stage takes the low stage's tc_o on trk_en_i and the shared parallel enable on cnt_en_i. The high stage then advances on exactly the edge where the low stage wraps, and its tc_o marks a combined count of 8'hFF.
- R8: The clear has priority over load. With rst_ni low and load_ni low, clock edges leave count_o at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous clear, active low |
| load_ni | input | 1 | Synchronous parallel load, active low |
| cnt_en_i | input | 1 | Parallel count enable |
| trk_en_i | input | 1 | Trickle count enable, also gates tc_o |
| preset_i | input | WIDTH | Value loaded when load_ni is low |
| count_o | output | WIDTH | Current count |
| tc_o | output | 1 | Terminal count: count is all ones and trk_en_i is high |

## Verification
The count register is the only state, so a wrong internal value appears on count_o in the same cycle it is captured. One edge later, a wrong increment or hold shows up as a step that differs from the previous value plus one, or from the previous value. A fault in the terminal-count logic or the increment carry surfaces in a chained pair. There the high stage steps one edge early or late around the low stage's wrap, and the bench compares the chained pair against an 8-bit model on every edge.

// File: rtl/cascade_cnt_pkg.sv
package cascade_cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/cascade_cnt_ctrl.sv
module cascade_cnt_ctrl
  import cascade_cnt_pkg::*;
(
  input  logic    load_ni,
  input  logic    cnt_en_i,
  input  logic    trk_en_i,
  output cnt_op_e op_o
);
  // load beats counting; counting needs both enables
  always_comb begin
    if (!load_ni)                  op_o = OP_LOAD;
    else if (cnt_en_i && trk_en_i) op_o = OP_COUNT;
    else                           op_o = OP_HOLD;
  end
endmodule

// File: rtl/cascade_cnt_next.sv
module cascade_cnt_next
  import cascade_cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic [WIDTH-1:0] preset_i,
  input  cnt_op_e          op_i,
  output logic [WIDTH-1:0] d_o
);
  logic [WIDTH-1:0] tog;
  logic [WIDTH-1:0] inc;

  // look-ahead: bit i toggles when every lower bit is one
  for (genvar i = 0; i < WIDTH; i++) begin : g_la
    if (i == 0) begin : g_lsb
      assign tog[i] = 1'b1;
    end else begin : g_up
      assign tog[i] = &q_i[i-1:0];
    end
    assign inc[i] = q_i[i] ^ tog[i];
  end

  always_comb begin
    unique case (op_i)
      OP_LOAD:  d_o = preset_i;
      OP_COUNT: d_o = inc;
      default:  d_o = q_i;
    endcase
  end
endmodule

// File: rtl/cascade_cnt_tc.sv
module cascade_cnt_tc #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             trk_en_i,
  output logic             tc_o
);
  assign tc_o = trk_en_i & (&q_i);
endmodule

// File: rtl/cascade_cnt.sv
module cascade_cnt
  import cascade_cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic             cnt_en_i,
  input  logic             trk_en_i,
  input  logic [WIDTH-1:0] preset_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_o
);
  localparam logic [WIDTH-1:0] MaxVal = {WIDTH{1'b1}};

  cnt_op_e          op;
  logic [WIDTH-1:0] cnt_d;
  logic [WIDTH-1:0] cnt_q;

  cascade_cnt_ctrl u_ctrl (
    .load_ni  (load_ni),
    .cnt_en_i (cnt_en_i),
    .trk_en_i (trk_en_i),
    .op_o     (op)
  );

  cascade_cnt_next #(.WIDTH(WIDTH)) u_next (
    .q_i      (cnt_q),
    .preset_i (preset_i),
    .op_i     (op),
    .d_o      (cnt_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  cascade_cnt_tc #(.WIDTH(WIDTH)) u_tc (
    .q_i      (cnt_q),
    .trk_en_i (trk_en_i),
    .tc_o     (tc_o)
  );

  assign count_o = cnt_q;

  // R1 R8
  clr_zero_chk: assert property (@(posedge clk_i) !rst_ni |-> count_o == '0);
  // R2
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> count_o == $past(preset_i));
  // R3
  inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && cnt_en_i && trk_en_i) |=> count_o == WIDTH'($past(count_o) + 1'b1));
  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !(cnt_en_i && trk_en_i)) |=> $stable(count_o));
  // R5
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && cnt_en_i && trk_en_i && count_o == MaxVal) |=> count_o == '0);
  // R6
  tc_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> (trk_en_i && count_o == MaxVal));
  // R6
  tc_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trk_en_i && count_o == MaxVal) |-> tc_o);
endmodule

// File: tb/cascade_cnt_tb.sv
module cascade_cnt_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       load_ni = 1'b1;
  logic       en_p = 1'b0;
  logic       en_t = 1'b0;
  logic [7:0] preset = '0;
  logic [3:0] cnt_lo, cnt_hi;
  logic       tc_lo, tc_hi;
  int         n_run = 0;
  int         n_fail = 0;
  logic       done = 1'b0;

  always #4 clk_i = ~clk_i;

  cascade_cnt u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_ni(load_ni), .cnt_en_i(en_p),
    .trk_en_i(en_t), .preset_i(preset[3:0]), .count_o(cnt_lo), .tc_o(tc_lo)
  );
  cascade_cnt u_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_ni(load_ni), .cnt_en_i(en_p),
    .trk_en_i(tc_lo), .preset_i(preset[7:4]), .count_o(cnt_hi), .tc_o(tc_hi)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one rising edge; inputs change and outputs are sampled at negedge
  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    check("R1 reset lo", cnt_lo, 0);
    check("R1 reset hi", cnt_hi, 0);
    check("R6 reset tc", tc_lo, 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_load();
    en_p = 1'b0; en_t = 1'b0; load_ni = 1'b0; preset = 8'hA5;
    step();
    check("R2 load no enables", {cnt_hi, cnt_lo}, 8'hA5);
    en_p = 1'b1; en_t = 1'b1; preset = 8'h3C;
    step();
    check("R2 load over enables", {cnt_hi, cnt_lo}, 8'h3C);
    load_ni = 1'b1;
  endtask

  task automatic t_count_hold();
    load_ni = 1'b0; preset = 8'h06; step(); load_ni = 1'b1;
    en_p = 1'b1; en_t = 1'b1;
    step(); check("R3 inc", cnt_lo, 7);
    step(); check("R3 inc", cnt_lo, 8);
    en_p = 1'b0;
    step(); check("R4 hold cnt_en low", cnt_lo, 8);
    en_p = 1'b1; en_t = 1'b0;
    step(); check("R4 hold trk_en low", cnt_lo, 8);
    en_t = 1'b1;
    step(); check("R3 inc resume", cnt_lo, 9);
  endtask

  task automatic t_tc_wrap();
    load_ni = 1'b0; preset = 8'h0F; en_p = 1'b0; en_t = 1'b0; step(); load_ni = 1'b1;
    check("R6 tc needs trk_en", tc_lo, 0);
    en_t = 1'b1; #1;
    check("R6 tc without cnt_en", tc_lo, 1);
    check("R4 hold at max", cnt_lo, 15);
    en_p = 1'b1;
    step();
    check("R5 wrap", cnt_lo, 0);
    check("R6 tc clears", tc_lo, 0);
  endtask

  task automatic t_clear();
    load_ni = 1'b0; preset = 8'h77; step(); load_ni = 1'b1;
    @(posedge clk_i); #1;
    rst_ni = 1'b0; #1;
    check("R1 async clear", {cnt_hi, cnt_lo}, 0);
    @(negedge clk_i);
    load_ni = 1'b0; preset = 8'h5A;
    step();
    check("R8 clear beats load", {cnt_hi, cnt_lo}, 0);
    load_ni = 1'b1;
    rst_ni = 1'b1;
  endtask

  task automatic t_cascade();
    logic [7:0] model;
    load_ni = 1'b0; preset = 8'hF0; step(); load_ni = 1'b1;
    model = 8'hF0;
    en_p = 1'b1; en_t = 1'b1;
    for (int i = 0; i < 300; i++) begin
      check("R7 tc chain", tc_hi, (model == 8'hFF) ? 1 : 0);
      step();
      model = model + 8'd1;
      check("R7 chained count", {cnt_hi, cnt_lo}, model);
    end
    en_p = 1'b0;
    load_ni = 1'b0; preset = 8'h2F; step(); load_ni = 1'b1;
    step();
    check("R7 high holds with low tc and no cnt_en", {cnt_hi, cnt_lo}, 8'h2F);
  endtask

  initial begin
    #2;
    @(negedge clk_i);
    t_reset();
    t_load();
    t_count_hold();
    t_tc_wrap();
    t_clear();
    t_cascade();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule